// File: doc/BRIEF.md
# Watchdog Timer With Reset Generator

This block watches for a stalled processor. An 8-bit up-counter advances on a clock enable taken from a free-running prescaler, with one of eight division ratios. Software keeps rewriting the counter, normally to zero, so that it never wraps. If the counter does wrap while the block is in watchdog mode, the block does three things. It pulls an active-low overflow output low for a fixed number of cycles. It sets a sticky overflow flag. If the reset-enable bit is set, it also drives an active-high internal reset for 518 cycles. While that reset is high, the counter and all control bits except the overflow flag are held at zero.

In interval mode the same wrap does not touch the overflow output or the reset. It sets an interval flag, and that flag drives an interrupt request. Both flags are cleared the same way: software reads the register with the flag at 1, then writes 0 to the flag bit. The external reset input is asynchronous and active low. It beats any reset that a watchdog overflow starts, and it clears the overflow flag.

Top module: `wdt_rst_gen`

## Requirements
- R1: After the external reset (rst_ni low) all three registers read 0x00, wdt_ovf_no is 1, and int_rst_o and irq_o are 0. The registers are: address 0 control, with bit 7 the interval flag, bit 6 the mode (1 = watchdog), bit 5 the enable and bits 2:0 the clock select. Address 1 is the counter. Address 2 is reset control, with bit 7 the overflow flag and bit 6 the reset enable. Address 3 and the undefined bits read 0.
- R2: The counter advances only while the enable bit is 1. It advances once every 2^s cycles, where s is 1, 2, 3, 4, 6, 8, 10 or 12 for select values 0 to 7. Setting the enable bit restarts the prescaler, so the first step comes 2^s cycles after the write.
- R3: wdt_ovf_no goes low only after a counter wrap while both the mode bit and the enable bit are 1.
- R4: While software rewrites the counter before it wraps, no overflow occurs and the overflow flag stays 0. A counter write in the same cycle as a step wins over the step.
- R5: A wrap in watchdog mode sets the overflow flag. When reset enable is 1, int_rst_o rises in the same cycle that wdt_ovf_no falls.
- R6: wdt_ovf_no stays low for 132 cycles if reset enable was 1 at the wrap, and for 130 cycles if it was 0.
- R7: int_rst_o, once started, stays high for 518 cycles.
- R8: A wrap in interval mode (mode bit 0) sets the interval flag and irq_o follows it. wdt_ovf_no and int_rst_o do not change.
- R9: A flag clears only when 0 is written to its bit after a read that returned it as 1. A write of 1, or a write of 0 with no such read before it, leaves the flag unchanged.
- R10: While int_rst_o is high, the counter, the control bits and reset enable read 0 and register writes are ignored. The overflow flag keeps its value of 1.
- R11: Pulling rst_ni low while a watchdog reset is active ends both pulses at once and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External reset, asynchronous, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, used to arm flag clearing |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| wdt_ovf_no | output | 1 | Overflow output, active low |
| int_rst_o | output | 1 | Internal reset output, active high |
| irq_o | output | 1 | Interval interrupt request |

## Verification
The bench uses the default parameters: an 8-bit counter, a 12-bit prescaler, and pulse lengths of 130, 132 and 518 cycles. That keeps both the fastest ratio (divide by 2) and the slowest (divide by 4096) within reach: the slowest produces two counter steps in about 8200 cycles. The counter is preloaded to 0xF0 or 0xFE so that a wrap arrives in a few dozen cycles. The pulse lengths are measured one cycle at a time, which means a pulse off by one cycle in either direction shows up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_RCTL = 2'd2
  } wdt_addr_e;

  // prescaler tap (log2 of division) per clock select
  function automatic int sel_shift(input int sel);
    case (sel)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      5: return 8;
      6: return 10;
      default: return 12;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import wdt_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [7:0]       taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < 8; g++) begin : g_tap
    localparam int SH = sel_shift(g);
    assign taps[g] = &pre_q[SH-1:0];
  end

  assign tick_o = run_i && taps[sel_i];

  a_r2_no_tick_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rem_q <= '0;
    else if (start_i)      rem_q <= len_i;
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign active_o = (rem_q != '0);

  a_r7_pulse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !start_i && rem_q != LEN_W'(1) |=> active_o);
  a_r6_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && len_i != '0 |=> active_o);
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (sync_clr_i) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_i) begin
      if (armed_q && !wbit_i) flag_o <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed_q <= 1'b1;
    end
  end

  a_r9_no_write_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o && !set_i |=> !flag_o);
  a_r9_clear_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !armed_q && !sync_clr_i |=> flag_o);
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int CNT_W         = 8,
  parameter int PRE_W         = 12,
  parameter int OVF_LEN_RST   = 132,
  parameter int OVF_LEN_NORST = 130,
  parameter int IRST_LEN      = 518
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdt_ovf_no,
  output logic       int_rst_o,
  output logic       irq_o
);
  import wdt_pkg::*;

  localparam int MAXLEN = max3(OVF_LEN_RST, OVF_LEN_NORST, IRST_LEN);
  localparam int LEN_W  = $clog2(MAXLEN + 1);

  logic             mode_q, en_q, rst_en_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap, wd_evt, iv_evt;
  logic             wr_ctrl, wr_cnt, wr_rctl, rd_ctrl, rd_rctl;
  logic             intv_flag, ovf_flag, ovf_active;
  logic [LEN_W-1:0] ovf_len;

  assign wr_ctrl = wr_en_i && !int_rst_o && addr_i == ADDR_CTRL;
  assign wr_cnt  = wr_en_i && !int_rst_o && addr_i == ADDR_CNT;
  assign wr_rctl = wr_en_i && !int_rst_o && addr_i == ADDR_RCTL;
  assign rd_ctrl = rd_en_i && addr_i == ADDR_CTRL;
  assign rd_rctl = rd_en_i && addr_i == ADDR_RCTL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= '0;
      rst_en_q <= 1'b0;
      cnt_q    <= '0;
    end else if (int_rst_o) begin
      mode_q   <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= '0;
      rst_en_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wdata_i[6];
        en_q   <= wdata_i[5];
        sel_q  <= wdata_i[2:0];
      end
      if (wr_rctl) rst_en_q <= wdata_i[6];
      if (wr_cnt)    cnt_q <= wdata_i[CNT_W-1:0];
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q && !int_rst_o),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  assign wrap   = tick && (cnt_q == '1) && !wr_cnt;
  assign wd_evt = wrap && mode_q;
  assign iv_evt = wrap && !mode_q;
  assign ovf_len = rst_en_q ? LEN_W'(OVF_LEN_RST) : LEN_W'(OVF_LEN_NORST);

  wdt_pulse #(.LEN_W(LEN_W)) u_ovf_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wd_evt),
    .len_i    (ovf_len),
    .active_o (ovf_active)
  );

  wdt_pulse #(.LEN_W(LEN_W)) u_rst_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wd_evt && rst_en_q),
    .len_i    (LEN_W'(IRST_LEN)),
    .active_o (int_rst_o)
  );

  wdt_flag u_intv_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (int_rst_o),
    .set_i      (iv_evt),
    .rd_i       (rd_ctrl),
    .wr_i       (wr_ctrl),
    .wbit_i     (wdata_i[7]),
    .flag_o     (intv_flag)
  );

  wdt_flag u_ovf_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (1'b0),
    .set_i      (wd_evt),
    .rd_i       (rd_rctl),
    .wr_i       (wr_rctl),
    .wbit_i     (wdata_i[7]),
    .flag_o     (ovf_flag)
  );

  assign wdt_ovf_no = !ovf_active;
  assign irq_o      = intv_flag;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o = {intv_flag, mode_q, en_q, 2'b00, sel_q};
      ADDR_CNT:  rdata_o = 8'(cnt_q);
      ADDR_RCTL: rdata_o = {ovf_flag, rst_en_q, 6'b0};
      default:   rdata_o = '0;
    endcase
  end

  a_r5_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst_o) |-> $fell(wdt_ovf_no));
  a_r5_flag_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_ovf_no) |-> ovf_flag);
  a_r3_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_ovf_no) |-> $past(mode_q && en_q));
  a_r10_hold_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |=> (cnt_q == '0 && !en_q && !mode_q && !rst_en_q));
  a_r10_keep_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o && ovf_flag |=> ovf_flag);
  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$fell(wdt_ovf_no) && !$rose(int_rst_o));
endmodule

// File: tb/wdt_rst_gen_test.sv
module wdt_rst_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdt_ovf_no, int_rst_o, irq_o;

  int total = 0, bad = 0, cyc = 0;
  int exp_ovf[$];
  int exp_irst[$];
  int ovf_run = 0, irst_run = 0, ovf_start = -1;
  logic [7:0] snap;

  always #2 clk = ~clk;

  wdt_rst_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wdt_ovf_no(wdt_ovf_no), .int_rst_o(int_rst_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  // monitor: measures pulses and pops expected lengths
  always @(negedge clk) begin
    if (!rst_ni) begin
      ovf_run = 0; irst_run = 0;
    end else begin
      if (!wdt_ovf_no) begin
        if (ovf_run == 0) ovf_start = cyc;
        ovf_run++;
      end else if (ovf_run > 0) begin
        if (exp_ovf.size() == 0) chk("R3/R4 unexpected overflow", ovf_run, 0);
        else chk("R6 overflow length", ovf_run, exp_ovf.pop_front());
        ovf_run = 0;
      end
      if (int_rst_o) begin
        if (irst_run == 0) chk("R5 reset starts with overflow", cyc, ovf_start);
        irst_run++;
      end else if (irst_run > 0) begin
        if (exp_irst.size() == 0) chk("R7 unexpected reset", irst_run, 0);
        else chk("R7 reset length", irst_run, exp_irst.pop_front());
        irst_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, snap); chk("R1 ctrl", snap, 8'h00);
    rd(2'd1, snap); chk("R1 cnt", snap, 8'h00);
    rd(2'd2, snap); chk("R1 rctl", snap, 8'h00);
    chk("R1 outputs", {wdt_ovf_no, int_rst_o, irq_o}, 3'b100);

    // R8 interval mode
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h20);
    wait_cyc(10);
    chk("R8 irq", irq_o, 1);
    chk("R8 no ovf output", {wdt_ovf_no, int_rst_o}, 2'b10);
    rd(2'd0, snap); chk("R8 interval flag", snap, 8'hA0);
    rd(2'd2, snap); chk("R3 no ovf flag in interval", snap, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, snap); chk("R9 interval flag cleared", snap, 8'h00);
    chk("R8 irq low", irq_o, 0);

    // R2 rate, divide by 16
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h23);
    wait_cyc(160);
    rd(2'd1, snap); chk("R2 div16 count", snap, 8'd10);
    wr(2'd0, 8'h03);
    rd(2'd1, snap);
    wait_cyc(50);
    begin
      logic [7:0] s2;
      rd(2'd1, s2); chk("R2 stopped when disabled", s2, snap);
    end
    // R2 divide by 4096
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h27);
    wait_cyc(8192);
    rd(2'd1, snap); chk("R2 div4096 count", snap, 8'd2);
    wr(2'd0, 8'h00);

    // R6 watchdog without reset
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hF0);
    exp_ovf.push_back(130);
    wr(2'd0, 8'h60);
    wait_cyc(300);
    wr(2'd0, 8'h00);
    chk("R7 no reset when disabled", int_rst_o, 0);
    rd(2'd2, snap); chk("R5 ovf flag set", snap, 8'h80);
    // R9 clear protocol
    wr(2'd2, 8'h80);
    wr(2'd2, 8'h00);
    rd(2'd2, snap); chk("R9 no clear without read", snap, 8'h80);
    wr(2'd2, 8'h00);
    rd(2'd2, snap); chk("R9 clear after read", snap, 8'h00);
    wr(2'd2, 8'h80);
    rd(2'd2, snap); chk("R9 write one no effect", snap, 8'h00);

    // R4 servicing
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h60);
    for (int i = 0; i < 15; i++) begin
      wait_cyc(12);
      wr(2'd1, 8'hF0);
    end
    wr(2'd0, 8'h00);
    rd(2'd2, snap); chk("R4 serviced no flag", snap, 8'h00);
    chk("R4 ovf idle", wdt_ovf_no, 1);

    // R5 R6 R7 R10 watchdog with reset
    wr(2'd2, 8'h40);
    wr(2'd1, 8'hF0);
    exp_ovf.push_back(132);
    exp_irst.push_back(518);
    wr(2'd0, 8'h60);
    wait_cyc(100);
    chk("R7 reset active", int_rst_o, 1);
    wr(2'd0, 8'h25);
    rd(2'd0, snap); chk("R10 write ignored in reset", snap, 8'h00);
    rd(2'd2, snap); chk("R10 flag kept", snap, 8'h80);
    wait_cyc(600);
    rd(2'd0, snap); chk("R10 ctrl cleared", snap, 8'h00);
    rd(2'd1, snap); chk("R10 cnt cleared", snap, 8'h00);
    rd(2'd2, snap); chk("R10 rctl after reset", snap, 8'h80);

    // R11 external reset beats watchdog reset
    wr(2'd2, 8'h40);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h60);
    wait_cyc(20);
    chk("R11 reset started", int_rst_o, 1);
    rst_ni = 1'b0;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk("R11 outputs idle", {wdt_ovf_no, int_rst_o}, 2'b10);
    rd(2'd2, snap); chk("R11 flag cleared", snap, 8'h00);

    chk("R6 pending overflows", exp_ovf.size(), 0);
    chk("R7 pending resets", exp_irst.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule